// File: doc/BRIEF.md
# Private Interrupt Pending Tracker

This block keeps the pending state of the private interrupts that belong to one processor. It has two parts. One is a latch that records events. The other is a stored copy of each peripheral input level. Each clock, the block samples the input lines:

- A rising edge on an input configured as edge-sensitive sets that interrupt's latch bit.
- An input configured as level-sensitive shows its live sampled level in the pending view and never touches the latch.

The register bank sends masked set and clear vectors. These are applied in the same cycle as sampling, and a clear always wins.

Software-generated interrupts arrive as requests. A request carries a target number, a requested group and a non-secure flag. The request passes through a gate before it can set the target's latch bit:

1. **Group match.** The interrupt's configured group is derived from its group bit and its group-modifier bit. A request for secure group 1 that lands on a group-0 interrupt is treated as a group-0 request. Any other group mismatch drops the request.
2. **Permission check.** A non-secure request made while security is enabled must also pass a two-bit per-interrupt permission field.

The composite pending vector drives the downstream priority logic. A one-cycle update pulse tells that logic when the latch or a stored level has changed.

The block has no state machine. Its state is two registered vectors, the latch and the stored levels. Each clock moves both vectors together from their current values to the next ones.

Top module: `priv_pend_tracker`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, the latch and stored levels are zero. With all lines low, `pend_view` is 0 and `upd_pulse` is 0.
- R2: A line sampled at the same value as its stored level changes nothing. If the latch is also unchanged, `upd_pulse` stays 0 in the following cycle.
- R3: A 0-to-1 change of `line_in[n]` with `edge_cfg[n]=1` sets latch bit n, and the bit stays set after the line falls. A level-sensitive line (`edge_cfg[n]=0`) never sets the latch.
- R4: `pend_view` equals latch OR (stored level AND NOT `edge_cfg`). It is visible in the cycle after the sampling edge.
- R5: The configured group of interrupt n is derived as follows:
  - `grp_bit[n]=1` gives non-secure group 1.
  - `grp_bit[n]=0` with `grpmod_bit[n]=0` gives group 0.
  - `grp_bit[n]=0` with `grpmod_bit[n]=1` gives secure group 1.
  - When `sec_off=1`, the modifier bit is ignored.
- R6: `sgi_grp` uses the encoding 0 = group 0, 1 = secure group 1, 2 = non-secure group 1. A request for secure group 1 whose target is configured as group 0 is treated as group 0. A request whose group still differs from the configured group is dropped.
- R7: When `sgi_ns=1` and `sec_off=0`, the permission field of target n is `acc_word[2n+1:2n]`. The thresholds are:
  - A group-0 target needs a field value of at least 1.
  - A secure group-1 target needs a field value of at least 2.
  - A non-secure group-1 target needs no permission.
  - A request below its threshold is dropped.
- R8: An accepted request with target `sgi_id` sets latch bit `sgi_id` (range 0–15), and that bit appears in `pend_view` one cycle later.
- R9: `sw_set[n]` sets latch bit n. `sw_clr[n]` clears latch bit n and overrides `sw_set`, an edge and a software interrupt on the same bit in the same cycle.
- R10: `upd_pulse` is high for exactly the one cycle after a clock edge at which the latch or any stored level changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | NUM_IRQ | Peripheral input lines, sampled each clock |
| edge_cfg | input | NUM_IRQ | 1 = edge-sensitive, 0 = level-sensitive |
| grp_bit | input | NUM_IRQ | Per-interrupt group bit |
| grpmod_bit | input | NUM_IRQ | Per-interrupt group-modifier bit |
| sec_off | input | 1 | 1 = security disabled |
| acc_word | input | 2*NUM_SGI | Two-bit non-secure permission field per software interrupt |
| sgi_valid | input | 1 | Software-interrupt request strobe |
| sgi_id | input | ID_W | Target number of the request |
| sgi_grp | input | 2 | Requested group (0 G0, 1 secure G1, 2 non-secure G1) |
| sgi_ns | input | 1 | Request is non-secure |
| sw_set | input | NUM_IRQ | Masked set-pending vector from the register bank |
| sw_clr | input | NUM_IRQ | Masked clear-pending vector from the register bank |
| pend_view | output | NUM_IRQ | Composite pending vector |
| upd_pulse | output | 1 | One-cycle change notification |

## Verification
The bench builds the block with its defaults: 32 interrupts, of which 16 are software-generated. With these values, software-interrupt target 5 has its permission field at bits 11:10. That lets the bench load every other field with the opposite value, so an indexing slip shows up as a wrong accept or a wrong drop.

The full 32-bit width keeps software targets, edge-sensitive lines (8–15) and level-sensitive lines (16 and up) in separate bit ranges. A leak between them is therefore visible in `pend_view`.

// File: rtl/priv_pend_pkg.sv
package priv_pend_pkg;

    typedef enum logic [1:0] {
        GRP_G0   = 2'd0,
        GRP_G1S  = 2'd1,
        GRP_G1NS = 2'd2
    } grp_e;

    // Configured group from the group bit and modifier bit (R5)
    function automatic grp_e derive_group(input logic gbit, input logic mbit, input logic sec_off);
        grp_e g;
        if (gbit)
            g = GRP_G1NS;
        else if (mbit && !sec_off)
            g = GRP_G1S;
        else
            g = GRP_G0;
        return g;
    endfunction

endpackage

// File: rtl/sgi_gate.sv
module sgi_gate
    import priv_pend_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int NUM_SGI = 16,
    localparam int ID_W   = $clog2(NUM_SGI)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ID_W-1:0]      req_id,
    input  logic [1:0]           req_grp,
    input  logic                 req_ns,
    input  logic                 sec_off,
    input  logic [NUM_IRQ-1:0]   grp_bit,
    input  logic [NUM_IRQ-1:0]   grpmod_bit,
    input  logic [2*NUM_SGI-1:0] acc_word,
    output logic [NUM_IRQ-1:0]   accept_vec
);

    grp_e       cfg_grp;
    grp_e       eff_grp;
    logic [1:0] acc_field;
    logic       grp_match;
    logic       perm_ok;
    logic       accept;

    always_comb begin
        cfg_grp   = derive_group(grp_bit[req_id], grpmod_bit[req_id], sec_off);
        eff_grp   = grp_e'(req_grp);
        // Fallback: secure group 1 on a group-0 target is treated as group 0 (R6)
        if (eff_grp == GRP_G1S && cfg_grp == GRP_G0)
            eff_grp = GRP_G0;
        grp_match = (eff_grp == cfg_grp);

        acc_field = acc_word[2*req_id +: 2];
        perm_ok   = 1'b1;
        if (req_ns && !sec_off) begin
            unique case (cfg_grp)
                GRP_G0:   perm_ok = (acc_field >= 2'd1);
                GRP_G1S:  perm_ok = (acc_field >= 2'd2);
                default:  perm_ok = 1'b1;
            endcase
        end

        accept     = req_valid && grp_match && perm_ok;
        accept_vec = '0;
        accept_vec[req_id] = accept;
    end

    // R8: at most one target accepted per request
    p_single_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(accept_vec));

    // R6: no acceptance without a request
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (accept_vec == '0));

endmodule

// File: rtl/line_sampler.sv
module line_sampler #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] line_in,
    input  logic [NUM_IRQ-1:0] edge_cfg,
    output logic [NUM_IRQ-1:0] lvl_q,
    output logic [NUM_IRQ-1:0] edge_hit,
    output logic               lvl_changed
);

    logic [NUM_IRQ-1:0] diff;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q[i] <= 1'b0;
            else if (line_in[i] != lvl_q[i])
                lvl_q[i] <= line_in[i];
        end
        assign diff[i]     = line_in[i] ^ lvl_q[i];
        assign edge_hit[i] = diff[i] & line_in[i] & edge_cfg[i];
    end

    assign lvl_changed = |diff;

    // R2: an unchanged sample leaves the stored level alone
    p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_in == lvl_q) |=> $stable(lvl_q));

endmodule

// File: rtl/pend_store.sv
module pend_store #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] edge_hit,
    input  logic [NUM_IRQ-1:0] sgi_hit,
    input  logic [NUM_IRQ-1:0] sw_set,
    input  logic [NUM_IRQ-1:0] sw_clr,
    input  logic               lvl_changed,
    output logic [NUM_IRQ-1:0] latch_q,
    output logic               upd_pulse
);

    logic [NUM_IRQ-1:0] latch_d;

    always_comb begin
        latch_d = (latch_q | edge_hit | sgi_hit | sw_set) & ~sw_clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q   <= '0;
            upd_pulse <= 1'b0;
        end else begin
            latch_q   <= latch_d;
            upd_pulse <= (latch_d != latch_q) || lvl_changed;
        end
    end

    // R9: a clear wins over every set source
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|sw_clr) |=> ((latch_q & $past(sw_clr)) == '0));

    // R3: an uncleared edge leaves its latch bit set
    p_edge_latches_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(edge_hit & ~sw_clr)) |=> ((latch_q & $past(edge_hit & ~sw_clr)) == $past(edge_hit & ~sw_clr)));

    // R10: any latch movement is announced
    p_latch_move_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q != $past(latch_q)) |-> upd_pulse);

endmodule

// File: rtl/priv_pend_tracker.sv
module priv_pend_tracker
    import priv_pend_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int NUM_SGI = 16,
    localparam int ID_W   = $clog2(NUM_SGI)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IRQ-1:0]   line_in,
    input  logic [NUM_IRQ-1:0]   edge_cfg,
    input  logic [NUM_IRQ-1:0]   grp_bit,
    input  logic [NUM_IRQ-1:0]   grpmod_bit,
    input  logic                 sec_off,
    input  logic [2*NUM_SGI-1:0] acc_word,
    input  logic                 sgi_valid,
    input  logic [ID_W-1:0]      sgi_id,
    input  logic [1:0]           sgi_grp,
    input  logic                 sgi_ns,
    input  logic [NUM_IRQ-1:0]   sw_set,
    input  logic [NUM_IRQ-1:0]   sw_clr,
    output logic [NUM_IRQ-1:0]   pend_view,
    output logic                 upd_pulse
);

    logic [NUM_IRQ-1:0] lvl_q;
    logic [NUM_IRQ-1:0] edge_hit;
    logic               lvl_changed;
    logic [NUM_IRQ-1:0] sgi_hit;
    logic [NUM_IRQ-1:0] latch_q;

    line_sampler #(.NUM_IRQ(NUM_IRQ)) u_sampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_in     (line_in),
        .edge_cfg    (edge_cfg),
        .lvl_q       (lvl_q),
        .edge_hit    (edge_hit),
        .lvl_changed (lvl_changed)
    );

    sgi_gate #(.NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (sgi_valid),
        .req_id     (sgi_id),
        .req_grp    (sgi_grp),
        .req_ns     (sgi_ns),
        .sec_off    (sec_off),
        .grp_bit    (grp_bit),
        .grpmod_bit (grpmod_bit),
        .acc_word   (acc_word),
        .accept_vec (sgi_hit)
    );

    pend_store #(.NUM_IRQ(NUM_IRQ)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_hit    (edge_hit),
        .sgi_hit     (sgi_hit),
        .sw_set      (sw_set),
        .sw_clr      (sw_clr),
        .lvl_changed (lvl_changed),
        .latch_q     (latch_q),
        .upd_pulse   (upd_pulse)
    );

    assign pend_view = latch_q | (lvl_q & ~edge_cfg);

    // R8: an accepted, uncleared request shows up in the view
    p_sgi_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sgi_hit & ~sw_clr)) |=> ((pend_view & $past(sgi_hit & ~sw_clr)) == $past(sgi_hit & ~sw_clr)));

    // R10: a stored-level change is announced
    p_level_move_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != $past(lvl_q)) |-> upd_pulse);

endmodule

// File: tb/priv_pend_tracker_test.sv
module priv_pend_tracker_test;

    localparam int NUM_IRQ = 32;
    localparam int NUM_SGI = 16;
    localparam int ID_W    = $clog2(NUM_SGI);
    localparam int TGT     = 5;
    localparam int NVEC    = 14;

    // {grp_bit, grpmod_bit, sec_off, req_grp[1:0], ns, acc[1:0], expect}
    localparam logic [8:0] VEC [NVEC] = '{
        9'b0_0_0_00_0_00_1,  // R6 G0 cfg, G0 req
        9'b0_0_0_01_0_00_1,  // R6 fallback G1S -> G0
        9'b0_0_0_10_0_00_0,  // R6 G1NS on G0 dropped
        9'b0_1_0_01_0_00_1,  // R5 G1S cfg, G1S req
        9'b0_1_0_00_0_00_0,  // R6 G0 on G1S dropped
        9'b1_0_0_10_1_00_1,  // R7 G1NS no permission needed
        9'b0_0_0_00_1_00_0,  // R7 G0 ns acc0 dropped
        9'b0_0_0_00_1_01_1,  // R7 G0 ns acc1
        9'b0_1_0_01_1_01_0,  // R7 G1S ns acc1 dropped
        9'b0_1_0_01_1_10_1,  // R7 G1S ns acc2
        9'b0_1_0_01_1_11_1,  // R7 G1S ns acc3
        9'b0_1_1_00_1_00_1,  // R5 sec off: modifier ignored, no check
        9'b0_1_1_01_1_00_1,  // R5 sec off: fallback to G0
        9'b0_1_0_10_0_00_0   // R6 G1NS on G1S dropped
    };

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NUM_IRQ-1:0]   line_in, edge_cfg, grp_bit, grpmod_bit, sw_set, sw_clr;
    logic                 sec_off, sgi_valid, sgi_ns;
    logic [2*NUM_SGI-1:0] acc_word;
    logic [ID_W-1:0]      sgi_id;
    logic [1:0]           sgi_grp;
    logic [NUM_IRQ-1:0]   pend_view;
    logic                 upd_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5ns clk = ~clk;

    priv_pend_tracker #(.NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI)) uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .edge_cfg(edge_cfg),
        .grp_bit(grp_bit), .grpmod_bit(grpmod_bit), .sec_off(sec_off),
        .acc_word(acc_word), .sgi_valid(sgi_valid), .sgi_id(sgi_id),
        .sgi_grp(sgi_grp), .sgi_ns(sgi_ns), .sw_set(sw_set), .sw_clr(sw_clr),
        .pend_view(pend_view), .upd_pulse(upd_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #2ms;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; line_in = '0; edge_cfg = 32'h0000_FF00;
        grp_bit = '0; grpmod_bit = '0; sec_off = 1'b0; acc_word = '0;
        sgi_valid = 1'b0; sgi_id = '0; sgi_grp = '0; sgi_ns = 1'b0;
        sw_set = '0; sw_clr = '0;
        repeat (3) step();
        chk("R1 view in reset", pend_view, 32'h0);
        chk("R1 pulse in reset", {31'b0, upd_pulse}, 32'h0);
        rst_n = 1'b1;
        step();
        chk("R1 view after reset", pend_view, 32'h0);
        chk("R1 pulse after reset", {31'b0, upd_pulse}, 32'h0);

        // level-sensitive line 20
        line_in[20] = 1'b1; step();
        chk("R4 level passes", pend_view, 32'h0010_0000);
        chk("R10 pulse on level rise", {31'b0, upd_pulse}, 32'h1);
        step();
        chk("R2 unchanged no pulse", {31'b0, upd_pulse}, 32'h0);
        chk("R4 level held", pend_view, 32'h0010_0000);
        line_in[20] = 1'b0; step();
        chk("R4 level falls", pend_view, 32'h0);
        chk("R10 pulse on level fall", {31'b0, upd_pulse}, 32'h1);

        // edge-sensitive line 9
        line_in[9] = 1'b1; step();
        chk("R3 edge latches", pend_view, 32'h0000_0200);
        line_in[9] = 1'b0; step();
        chk("R3 latch survives fall", pend_view, 32'h0000_0200);
        chk("R10 pulse on stored fall", {31'b0, upd_pulse}, 32'h1);

        // level line 22 never latches
        line_in[22] = 1'b1; sw_clr = 32'h0000_0200; step();
        sw_clr = '0;
        chk("R9 clear and level view", pend_view, 32'h0040_0000);
        line_in[22] = 1'b0; step();
        chk("R3 level line not latched", pend_view, 32'h0);

        // software set and clear priority
        sw_set = 32'h0000_0008; step();
        chk("R9 set", pend_view, 32'h0000_0008);
        sw_set = 32'h0000_0008; sw_clr = 32'h0000_0408; line_in[10] = 1'b1; step();
        chk("R9 clear beats set and edge", pend_view, 32'h0);
        sw_set = '0; sw_clr = '0; step();
        chk("R2 held edge line no relatch", pend_view, 32'h0);
        chk("R2 no pulse when idle", {31'b0, upd_pulse}, 32'h0);
        line_in[10] = 1'b0; step();
        line_in[10] = 1'b1; step();
        chk("R3 new edge latches", pend_view, 32'h0000_0400);
        sw_clr = '1; line_in[10] = 1'b0; step();
        sw_clr = '0; step();

        // SGI acceptance table on target 5 (field bits 11:10)
        for (int k = 0; k < NVEC; k++) begin
            logic [8:0] v;
            v = VEC[k];
            grp_bit    = {NUM_IRQ{v[8]}};
            grpmod_bit = {NUM_IRQ{v[7]}};
            sec_off    = v[6];
            acc_word   = v[0] ? '0 : '1;
            acc_word[2*TGT +: 2] = v[2:1];
            sw_clr = '1; step();
            sw_clr = '0;
            sgi_valid = 1'b1; sgi_id = ID_W'(TGT); sgi_grp = v[5:4]; sgi_ns = v[3];
            step();
            sgi_valid = 1'b0;
            chk($sformatf("R8/R6/R7 sgi vec %0d view", k), pend_view, v[0] ? 32'h0000_0020 : 32'h0);
            chk($sformatf("R10 sgi vec %0d pulse", k), {31'b0, upd_pulse}, {31'b0, v[0]});
        end

        // SGI with simultaneous clear
        grp_bit = '0; grpmod_bit = '0; sec_off = 1'b0;
        sw_clr = '1; step();
        sgi_valid = 1'b1; sgi_id = 4'd15; sgi_grp = 2'd0; sgi_ns = 1'b0;
        sw_clr = 32'h0000_8000; step();
        sgi_valid = 1'b0; sw_clr = '0;
        chk("R9 clear beats sgi", pend_view, 32'h0);
        sgi_valid = 1'b1; step();
        sgi_valid = 1'b0;
        chk("R8 top target", pend_view, 32'h0000_8000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule